// File: doc/BRIEF.md
# Byte Register Bank Target on a Two-Wire Serial Bus

This block is a target on a two-wire serial bus (I2C). It gives a bus host read and write access to a small bank of byte-wide control registers. It watches the clock and data lines and pulls the data line low through an open-drain enable. It recognises START, repeated START and STOP conditions. It answers only to one fixed 7-bit device address. The register contents are also presented in parallel on an output bus, so that nearby logic can use them as control values.

In a write, the host sends the device address with the direction bit low. The first data byte becomes the register pointer. Every later byte is stored in the register it names, and the pointer then moves forward. In a read, the host sends the address with the direction bit high, and the target returns bytes from the pointed register onward. The pointer is shared by both directions and survives a STOP. A read with no preceding pointer byte therefore resumes one past the last byte touched. A random read is a pointer-only write, then a repeated START and a read.

The pointer counter is wider than the register window. It steps by one after each data byte, and from the last register it wraps back to register zero.

Top module: `i2c_regbank_target`

## Requirements
- R1: After the synchronous reset, the SDA pull-down enable is off, all registers read 00h and the pointer is 00h, so a first current-address read returns register 0.
- R2: The target acknowledges only its own 7-bit device address. Bits 7..1 of the first byte after START carry the address and bit 0 carries the direction (1 = read). On any other address it gives no acknowledge and keeps SDA released until the next START or STOP.
- R3: In a write, the first data byte loads the pointer. Each later data byte is stored into the register selected by the pointer, and every data byte is acknowledged.
- R4: The pointer moves forward by exactly one after each stored or transmitted data byte, but not after the pointer byte. From register 7 it wraps to register 0.
- R5: A read with no pointer byte starts at one past the last register read or written, and this holds across STOP conditions.
- R6: A pointer-only write followed by a repeated START and a read returns data starting at the register that was just pointed to.
- R7: In a read, a host acknowledge after a data byte makes the target send the next register. A host non-acknowledge followed by STOP leaves SDA released.
- R8: The SDA pull-down enable changes only while SCL is low.
- R9: A STOP in the middle of a data byte drops that byte: no register changes. The next transaction is decoded normally, with the pointer that was in force.
- R10: Register contents change only when a write data byte completes. Traffic to another device address leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | Registered pull-down enable for SDA (1 drives the line low) |
| regs_o | output | NUM_REGS*8 | All registers; register k sits in bits 8k+7..8k |

## Verification
The checks assume that each SCL phase lasts several system clocks longer than the synchronizer delay. They also assume that the host changes SDA only while SCL is low, except when it forms START and STOP. With those assumptions, the pull-down enable, which is updated a few cycles after a synchronized falling edge, cannot change while the raw SCL pin is high. The bench's bus model holds each quarter bit period for eight system clocks. It builds START and STOP only from a settled SCL-high level, and it models the shared line as a wired-AND of host and target, so both sides see the same value.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK,
    ST_SKIP
  } rb_state_t;
endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_ff[SYNC_STAGES-1];
      sda_d  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_ff[SYNC_STAGES-1];
  assign sda_s     = sda_ff[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // data edges while the clock is steadily high are bus conditions
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_rb_regfile.sv
module i2c_rb_regfile #(
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_flat
);
  logic [7:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_REGS; k++) mem[k] <= 8'h00;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_flat[g*8 +: 8] = mem[g];
  end
endmodule

// File: rtl/i2c_rb_ctrl.sv
module i2c_rb_ctrl
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  parameter int NUM_REGS         = 8,
  parameter int PTR_W            = 6,
  localparam int IDX_W           = $clog2(NUM_REGS),
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data,
  output logic [IDX_W-1:0] idx,
  output logic             wr_en,
  output logic [7:0]       wr_data,
  output logic             sda_oe,
  output logic [PTR_W-1:0] ptr,
  output logic             ptr_load,
  output logic             ptr_adv
);
  rb_state_t  state;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       rw, first, ph, mack;
  logic       byte_done;
  logic [PTR_W-1:0] ptr_next;

  always_comb begin
    byte_done = scl_rise && (cnt == 4'd7);
    wr_data   = {sh[6:0], sda_s};
    ptr_load  = (state == ST_WR) && byte_done && first;
    wr_en     = (state == ST_WR) && byte_done && !first;
    ptr_adv   = wr_en || ((state == ST_RD) && byte_done);
    ptr_next  = (ptr >= LAST) ? '0 : ptr + 1'b1;
    idx       = ptr[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      sh    <= '0;
      sda_oe <= 1'b0;
      rw    <= 1'b0;
      first <= 1'b0;
      ph    <= 1'b0;
      mack  <= 1'b0;
      ptr   <= '0;
    end else begin
      if (ptr_load)     ptr <= wr_data[PTR_W-1:0];
      else if (ptr_adv) ptr <= ptr_next;

      if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: if (scl_rise) begin
            sh  <= wr_data;
            cnt <= cnt + 1'b1;
            if (cnt == 4'd7) begin
              ph    <= 1'b0;
              rw    <= sda_s;
              state <= (sh[6:0] == DEV_ADDR) ? ST_AACK : ST_SKIP;
            end
          end
          ST_AACK: if (scl_fall) begin
            if (!ph) begin
              sda_oe <= 1'b1;
              ph     <= 1'b1;
            end else begin
              ph  <= 1'b0;
              cnt <= '0;
              if (rw) begin
                state  <= ST_RD;
                sh     <= rd_data;
                sda_oe <= ~rd_data[7];
              end else begin
                state  <= ST_WR;
                sda_oe <= 1'b0;
                first  <= 1'b1;
              end
            end
          end
          ST_WR: if (scl_rise) begin
            sh  <= wr_data;
            cnt <= cnt + 1'b1;
            if (cnt == 4'd7) begin
              state <= ST_WACK;
              ph    <= 1'b0;
            end
          end
          ST_WACK: if (scl_fall) begin
            if (!ph) begin
              sda_oe <= 1'b1;
              ph     <= 1'b1;
            end else begin
              ph     <= 1'b0;
              sda_oe <= 1'b0;
              cnt    <= '0;
              first  <= 1'b0;
              state  <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                sda_oe <= ~sh[6];
                sh     <= {sh[6:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                state  <= ST_RD;
                cnt    <= '0;
                sh     <= rd_data;
                sda_oe <= ~rd_data[7];
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  parameter int NUM_REGS         = 8,
  parameter int PTR_W            = 6,
  parameter int SYNC_STAGES      = 2,
  localparam int IDX_W           = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [IDX_W-1:0] idx;
  logic [7:0] rd_data, wr_data;
  logic wr_en, ptr_load, ptr_adv;
  logic [PTR_W-1:0] ptr_q;

  i2c_rb_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_rb_ctrl #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) ctrl_i (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data),
    .idx(idx), .wr_en(wr_en), .wr_data(wr_data), .sda_oe(sda_oe_o),
    .ptr(ptr_q), .ptr_load(ptr_load), .ptr_adv(ptr_adv)
  );

  i2c_rb_regfile #(.NUM_REGS(NUM_REGS)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(idx), .wr_data(wr_data),
    .rd_idx(idx), .rd_data(rd_data), .regs_flat(regs_o)
  );

  logic unused_scl_s;
  assign unused_scl_s = scl_s;
endmodule

// File: rtl/i2c_regbank_target_chk.sv
module i2c_regbank_target_chk #(
  parameter int NUM_REGS = 8,
  parameter int PTR_W    = 6
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scl_i,
  input logic                  sda_oe_o,
  input logic                  stop_det,
  input logic [PTR_W-1:0]      ptr,
  input logic                  ptr_load,
  input logic                  ptr_adv,
  input logic                  wr_en,
  input logic [NUM_REGS*8-1:0] regs
);
  // R1
  reset_release_chk: assert property (@(posedge clk) rst |=> !sda_oe_o);

  // R8
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe_o) |-> !scl_i);

  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe_o);

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr_adv && !ptr_load) |=> (ptr == '0) || (ptr == $past(ptr) + 1'b1));

  // R4
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr_adv && !ptr_load && ptr >= PTR_W'(NUM_REGS - 1)) |=> (ptr == '0));

  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ptr_adv && !ptr_load) |=> $stable(ptr));

  // R10
  regs_write_only_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(regs) |-> $past(wr_en));
endmodule

bind i2c_regbank_target i2c_regbank_target_chk #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe_o(sda_oe_o), .stop_det(stop_det),
  .ptr(ptr_q), .ptr_load(ptr_load), .ptr_adv(ptr_adv), .wr_en(wr_en), .regs(regs_o)
);

// File: tb/i2c_regbank_target_tb_top.sv
module i2c_regbank_target_tb_top;
  localparam logic [6:0] ADDR = 7'h2C;
  localparam int NR = 8;
  localparam int Q  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe_o;
  logic [NR*8-1:0] regs_o;
  wire  sda_line = ~(m_low | sda_oe_o);

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_reg [NR];
  int mptr = 0;
  bit done = 1'b0;
  logic oe_prev = 1'b0;

  always #5 clk = ~clk;

  i2c_regbank_target dut_i (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe_o), .regs_o(regs_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R8: monitor that the target never moves SDA while SCL is high
  always @(posedge clk) begin
    if (!rst && !done && sda_oe_o !== oe_prev && m_scl) begin
      errors++;
      $display("FAIL R8 actual=%0d expected=%0d", sda_oe_o, oe_prev);
    end
    oe_prev <= sda_oe_o;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; tick(Q); m_scl = 1'b1; tick(Q);
    m_low = 1'b1; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    m_low = 1'b0; tick(2*Q);
  endtask

  task automatic clk_bit(input bit b, output bit s);
    m_low = !b; tick(Q); m_scl = 1'b1; tick(Q);
    s = sda_line; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    bit s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      d = {d[6:0], s};
    end
    clk_bit(!mack, s);
  endtask

  function automatic int adv(input int p);
    return (p >= NR - 1) ? 0 : p + 1;
  endfunction

  task automatic do_write(input int p, input int n, input int base, input int step);
    bit ack;
    bus_start();
    send_byte({ADDR, 1'b0}, ack); chk(ack, "R2 addr ack", ack, 1);
    send_byte(8'(p), ack);        chk(ack, "R3 ptr ack", ack, 1);
    mptr = p;
    for (int i = 0; i < n; i++) begin
      logic [7:0] v;
      v = 8'(base + step * i);
      send_byte(v, ack);
      chk(ack, "R3 data ack", ack, 1);
      exp_reg[mptr] = v;
      mptr = adv(mptr);
    end
    bus_stop();
    for (int k = 0; k < NR; k++)
      chk(regs_o[k*8 +: 8] == exp_reg[k], "R3 R4 stored value", regs_o[k*8 +: 8], exp_reg[k]);
  endtask

  task automatic do_read(input bit random, input int p, input int n, input string req);
    bit ack;
    logic [7:0] d;
    bus_start();
    if (random) begin
      send_byte({ADDR, 1'b0}, ack);
      send_byte(8'(p), ack);
      mptr = p;
      bus_start();
    end
    send_byte({ADDR, 1'b1}, ack);
    chk(ack, "R2 read addr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk(d == exp_reg[mptr], req, d, exp_reg[mptr]);
      mptr = adv(mptr);
    end
    bus_stop();
    tick(4);
    chk(sda_oe_o == 1'b0, "R7 released after NACK+STOP", sda_oe_o, 0);
  endtask

  initial begin
    bit ack;
    bit s;
    logic [NR*8-1:0] snap;
    for (int k = 0; k < NR; k++) exp_reg[k] = 8'h00;
    tick(5);
    rst = 1'b0;
    tick(5);
    // R1 reset state
    chk(sda_oe_o == 1'b0, "R1 oe after reset", sda_oe_o, 0);
    chk(regs_o == '0, "R1 regs after reset", 0, 0);
    mptr = 0;
    do_read(1'b0, 0, 1, "R1 R5 first current read");
    // R3: fill all registers from 0, pointer wraps back to 0
    do_write(0, NR, 5, 37);
    // R4 R7: long current read wraps around the window
    do_read(1'b0, 0, 10, "R4 R7 wrap read");
    // R6 R5: random read sweep, then current read continues
    for (int p = 0; p < NR; p++) begin
      do_read(1'b1, p, 3, "R6 random read");
      do_read(1'b0, 0, 1, "R5 current read");
    end
    // R4: write crossing the top of the window
    do_write(6, 4, 8'hA0, 3);
    do_read(1'b0, 0, 2, "R5 read after wrapped write");
    // R2 R10: foreign address
    snap = regs_o;
    bus_start();
    send_byte({ADDR ^ 7'h01, 1'b0}, ack);
    chk(!ack, "R2 foreign addr nack", ack, 0);
    send_byte(8'h03, ack);
    chk(!ack, "R2 released after foreign addr", ack, 0);
    send_byte(8'h77, ack);
    bus_stop();
    chk(regs_o == snap, "R10 foreign traffic no change", 0, 0);
    // R9: STOP inside a data byte after pointer byte 3
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    send_byte(8'h03, ack);
    mptr = 3;
    for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
    bus_stop();
    tick(4);
    chk(regs_o == snap, "R9 aborted byte not stored", 0, 0);
    chk(sda_oe_o == 1'b0, "R9 oe after abort", sda_oe_o, 0);
    do_read(1'b0, 0, 2, "R9 read after abort");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule